// File: doc/BRIEF.md
# Self-Timed EEPROM Write-and-Poll Sequencer

This block sits on the host side of a byte-wide parallel EEPROM whose writes are timed inside the memory. It accepts one request at a time through a valid/ready handshake. A request is either a byte write or a plain read. The block then drives the active-low chip-select, read-strobe and write-strobe lines, the address, and the write data with its bus-drive enable. Pulse widths and setup and hold gaps are counted in clock cycles.

A write does not end after a fixed wait. The sequencer finds the end of the memory's internal write cycle by one of two methods, chosen per request:

- **Polling:** it reads the same location again and again until the top data bit reads back equal to the written bit. The memory returns that bit inverted while it is still busy.
- **Ready line:** it waits for the ready line to go high.

It then makes one confirming read, returns the byte it read, and reports whether all bits match the written value. If completion is not seen within a set limit, the request ends with an error flag. No new access is started until a request has finished.

Top module: `eep_wr_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, chip-select, read-strobe and write-strobe are high (inactive), the bus drive enable is low, `rsp_done` is low and `req_ready` is high.
- R2: For a write, write-strobe goes low only while chip-select is low and read-strobe is high. It stays low for exactly `WE_CYC` cycles. While it is low, the address and write data are driven, enabled onto the bus and held constant.
- R3: The bus drive enable is never high while read-strobe is low. In the cycle before read-strobe falls, the drive enable is already low.
- R4: With `use_rdy_line` = 0 sampled at acceptance, the sequencer reads the written address repeatedly (chip-select and read-strobe low, write-strobe high). It stops polling at the first read whose bit 7 equals bit 7 of the written byte.
- R5: With `use_rdy_line` = 1 sampled at acceptance, no read is issued while `mem_rdy` is low after the write pulse. Completion is taken from `mem_rdy` being high.
- R6: `req_ready` is high only when the sequencer is idle, and drops in the cycle after a request is accepted. No strobe is active while `req_ready` is high. No new write begins while the memory is still busy.
- R7: After completion is detected, exactly one confirming read of the address is made. `rsp_done` then pulses with `rsp_rdata` set to the byte read and `rsp_match` = 1 only if all 8 bits equal the written byte.
- R8: In polling mode, if `MAX_POLLS` consecutive polls all fail, the request ends with `rsp_done`, `rsp_err` = 1 and `rsp_match` = 0. No confirming read is made, and the sequencer returns to idle.
- R9: In ready-line mode, if `mem_rdy` stays low for `MAX_WAIT` cycles, the request ends with `rsp_err` = 1 and no read is made.
- R10: A read request (`req_write` = 0) makes one read access of `req_addr` and ends with `rsp_done`, `rsp_rdata` equal to the stored byte and `rsp_err` = 0.
- R11: `rsp_done` is a one-cycle pulse. `rsp_err`, `rsp_match` and `rsp_rdata` hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken when valid is high |
| req_write | input | 1 | 1 = byte write, 0 = plain read |
| req_addr | input | AW | Memory address |
| req_wdata | input | DW | Byte to write |
| use_rdy_line | input | 1 | 1 = completion from ready line, 0 = data polling |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion timed out |
| rsp_match | output | 1 | Confirming read equals the written byte |
| rsp_rdata | output | DW | Byte from the last read |
| mem_ce_n | output | 1 | Chip-select, active low |
| mem_oe_n | output | 1 | Read-strobe, active low |
| mem_we_n | output | 1 | Write-strobe, active low |
| mem_addr | output | AW | Address to memory |
| mem_dq_out | output | DW | Write data to the bus |
| mem_dq_oe | output | 1 | Host drives the data bus |
| mem_dq_in | input | DW | Data bus read value |
| mem_rdy | input | 1 | Ready line, high when the memory is not busy |

## Verification
The hardest condition to reach is a write whose polling never succeeds, because a normal memory always finishes. The bench memory model takes a busy length for each request. A directed case sets it well beyond `MAX_POLLS` poll periods, and another sets it beyond `MAX_WAIT` in ready-line mode. The model then counts reads made while busy and after busy.

A second hard condition is a completed write that reads back wrong. For this, the model can corrupt the low seven stored bits while keeping bit 7 correct. Polling then succeeds but the confirming read shows the mismatch.

// File: rtl/eep_seq_pkg.sv
package eep_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WSETUP,
    S_WPULSE,
    S_WHOLD,
    S_TURN,
    S_RACC,
    S_EVAL,
    S_BWAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_READ,
    PH_POLL,
    PH_FINAL
  } rd_phase_e;
endpackage

// File: rtl/eep_phase_timer.sv
module eep_phase_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/eep_limit_cnt.sv
module eep_limit_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/eep_rd_capture.sv
module eep_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] expect_byte,
  output logic [DW-1:0] sample,
  output logic          top_ok,
  output logic          all_ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sample <= '0;
    end else if (cap) begin
      sample <= din;
    end
  end

  assign top_ok = (sample[DW-1] == expect_byte[DW-1]);
  assign all_ok = (sample == expect_byte);
endmodule

// File: rtl/eep_wr_seq.sv
module eep_wr_seq
  import eep_seq_pkg::*;
#(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int WE_CYC    = 3,
  parameter int HOLD_CYC  = 2,
  parameter int ACC_CYC   = 2,
  parameter int MAX_POLLS = 16,
  parameter int MAX_WAIT  = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          use_rdy_line,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic          rsp_match,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  input  logic          mem_rdy
);
  localparam int TMAX_A = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
  localparam int TMAX_B = (HOLD_CYC > ACC_CYC) ? HOLD_CYC : ACC_CYC;
  localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TW     = $clog2(TMAX + 1);

  seq_state_e state, state_nxt;
  rd_phase_e  phase, phase_nxt;

  logic          mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  logic          tmr_load;
  logic [TW-1:0] tmr_len;
  logic          tmr_zero;
  logic          poll_clr, poll_inc, poll_hit;
  logic          wait_clr, wait_inc, wait_hit;
  logic          cap;
  logic [DW-1:0] sample;
  logic          top_ok, all_ok;
  logic          accept;
  logic          done_nxt, err_nxt, match_nxt;
  logic [DW-1:0] rdata_nxt;

  eep_phase_timer #(.TW(TW)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .len  (tmr_len),
    .zero (tmr_zero)
  );

  eep_limit_cnt #(.LIMIT(MAX_POLLS)) u_poll_lim (
    .clk (clk),
    .rst (rst),
    .clr (poll_clr),
    .inc (poll_inc),
    .hit (poll_hit)
  );

  eep_limit_cnt #(.LIMIT(MAX_WAIT)) u_wait_lim (
    .clk (clk),
    .rst (rst),
    .clr (wait_clr),
    .inc (wait_inc),
    .hit (wait_hit)
  );

  eep_rd_capture #(.DW(DW)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .cap         (cap),
    .din         (mem_dq_in),
    .expect_byte (wdata_q),
    .sample      (sample),
    .top_ok      (top_ok),
    .all_ok      (all_ok)
  );

  assign accept = (state == S_IDLE) && req_valid && req_ready;

  always_comb begin
    state_nxt = state;
    phase_nxt = phase;
    tmr_load  = 1'b0;
    tmr_len   = '0;
    poll_clr  = 1'b0;
    poll_inc  = 1'b0;
    wait_clr  = 1'b0;
    wait_inc  = 1'b0;
    cap       = 1'b0;
    done_nxt  = 1'b0;
    err_nxt   = rsp_err;
    match_nxt = rsp_match;
    rdata_nxt = rsp_rdata;
    unique case (state)
      S_IDLE: begin
        if (accept) begin
          err_nxt   = 1'b0;
          match_nxt = 1'b0;
          poll_clr  = 1'b1;
          wait_clr  = 1'b1;
          if (req_write) begin
            state_nxt = S_WSETUP;
            tmr_load  = 1'b1;
            tmr_len   = TW'(SETUP_CYC);
          end else begin
            state_nxt = S_TURN;
            phase_nxt = PH_READ;
          end
        end
      end
      S_WSETUP: begin
        if (tmr_zero) begin
          state_nxt = S_WPULSE;
          tmr_load  = 1'b1;
          tmr_len   = TW'(WE_CYC);
        end
      end
      S_WPULSE: begin
        if (tmr_zero) begin
          state_nxt = S_WHOLD;
          tmr_load  = 1'b1;
          tmr_len   = TW'(HOLD_CYC);
        end
      end
      S_WHOLD: begin
        if (tmr_zero) begin
          if (mode_q) begin
            state_nxt = S_BWAIT;
          end else begin
            state_nxt = S_TURN;
            phase_nxt = PH_POLL;
          end
        end
      end
      S_TURN: begin
        state_nxt = S_RACC;
        tmr_load  = 1'b1;
        tmr_len   = TW'(ACC_CYC);
      end
      S_RACC: begin
        if (tmr_zero) begin
          cap       = 1'b1;
          state_nxt = S_EVAL;
        end
      end
      S_EVAL: begin
        unique case (phase)
          PH_POLL: begin
            if (top_ok) begin
              state_nxt = S_TURN;
              phase_nxt = PH_FINAL;
            end else if (poll_hit) begin
              state_nxt = S_IDLE;
              done_nxt  = 1'b1;
              err_nxt   = 1'b1;
            end else begin
              poll_inc  = 1'b1;
              state_nxt = S_TURN;
            end
          end
          PH_FINAL: begin
            state_nxt = S_IDLE;
            done_nxt  = 1'b1;
            match_nxt = all_ok;
            rdata_nxt = sample;
          end
          default: begin
            state_nxt = S_IDLE;
            done_nxt  = 1'b1;
            rdata_nxt = sample;
          end
        endcase
      end
      S_BWAIT: begin
        if (mem_rdy) begin
          state_nxt = S_TURN;
          phase_nxt = PH_FINAL;
        end else if (wait_hit) begin
          state_nxt = S_IDLE;
          done_nxt  = 1'b1;
          err_nxt   = 1'b1;
        end else begin
          wait_inc = 1'b1;
        end
      end
      default: state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      phase     <= PH_READ;
      mode_q    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      req_ready <= 1'b1;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_match <= 1'b0;
      rsp_rdata <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      state     <= state_nxt;
      phase     <= phase_nxt;
      if (accept) begin
        mode_q  <= use_rdy_line;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      req_ready <= (state_nxt == S_IDLE);
      rsp_done  <= done_nxt;
      rsp_err   <= err_nxt;
      rsp_match <= match_nxt;
      rsp_rdata <= rdata_nxt;
      mem_ce_n  <= !(state_nxt inside {S_WSETUP, S_WPULSE, S_WHOLD, S_RACC});
      mem_oe_n  <= (state_nxt != S_RACC);
      mem_we_n  <= (state_nxt != S_WPULSE);
      mem_dq_oe <= (state_nxt inside {S_WSETUP, S_WPULSE, S_WHOLD});
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
endmodule

// File: rtl/eep_wr_seq_chk.sv
module eep_wr_seq_chk #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          rsp_err,
  input logic          rsp_match,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n)); // R2
  AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe); // R2
  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R2
  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe); // R3
  AST_OE_FALL_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R3
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n)); // R6
  AST_ERR_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> !rsp_match); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R11
endmodule

bind eep_wr_seq eep_wr_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_eep_wr_seq.sv
module sim_eep_wr_seq;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int WE_CYC = 3;
  localparam int MAX_POLLS = 16;
  localparam int MAX_WAIT = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, use_rdy_line = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_done, rsp_err, rsp_match;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_rdy;
  logic [AW-1:0] mem_addr;

  eep_wr_seq #(.AW(AW), .DW(DW), .SETUP_CYC(2), .WE_CYC(WE_CYC), .HOLD_CYC(2),
               .ACC_CYC(2), .MAX_POLLS(MAX_POLLS), .MAX_WAIT(MAX_WAIT)) u0 (.*);

  int checks = 0;
  int fails = 0;

  // memory model state
  logic [7:0] shadow [64];
  int   busy = 0;
  logic pend7 = 1'b0;
  int   busy_len = 10;
  logic [6:0] cmask = '0;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  logic [AW-1:0] wr_addr = '0;
  int we_len = 0, we_width = 0, rd_busy = 0, rd_idle = 0, viol = 0, wr_cnt = 0;

  assign mem_rdy   = (busy == 0);
  assign mem_dq_in = (busy != 0) ? {~pend7, 7'h2A} : shadow[mem_addr[5:0]];

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) shadow[i] = 8'(i * 37 + 5);
      busy = 0;
      prev_we = 1'b1;
      prev_oe = 1'b1;
    end else begin
      if (!prev_oe && mem_oe_n) begin
        if (busy != 0) rd_busy++; else rd_idle++;
      end
      if (!mem_oe_n && mem_dq_oe) viol++;
      if (busy > 0) busy--;
      if (prev_we && !mem_we_n) begin
        wr_addr = mem_addr;
        we_len = 0;
        if (busy != 0) viol++;
      end
      if (!mem_we_n) begin
        we_len++;
        if (mem_addr != wr_addr || mem_ce_n || !mem_oe_n || !mem_dq_oe) viol++;
      end
      if (!prev_we && mem_we_n) begin
        if (!mem_dq_oe || mem_ce_n) viol++;
        shadow[wr_addr[5:0]] = mem_dq_out ^ {1'b0, cmask};
        pend7 = mem_dq_out[7];
        busy = busy_len;
        we_width = we_len;
        wr_cnt++;
      end
      prev_we = mem_we_n;
      prev_oe = mem_oe_n;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [7:0] d,
                         input bit rdy_mode, input int blen, input logic [6:0] msk,
                         input bit exp_to);
    int rb0, ri0, w0, v0, leak, n;
    logic e_q, m_q;
    logic [7:0] r_q, exp_rd;
    rb0 = rd_busy; ri0 = rd_idle; w0 = wr_cnt; v0 = viol; leak = 0; n = 0;
    exp_rd = shadow[a[5:0]];
    busy_len = blen;
    cmask = msk;
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; use_rdy_line = rdy_mode;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done && n < 3000) begin
      if (req_ready) leak++;
      @(negedge clk);
      n++;
    end
    chk(n < 3000, "R6", "completion seen", n, 0);
    e_q = rsp_err; m_q = rsp_match; r_q = rsp_rdata;
    @(negedge clk);
    chk(!rsp_done, "R11", "done single cycle", int'(rsp_done), 0);
    chk(rsp_err == e_q && rsp_match == m_q && rsp_rdata == r_q, "R11", "status held",
        int'(rsp_rdata), int'(r_q));
    chk(leak == 0, "R6", "ready low while busy", leak, 0);
    chk(viol == v0, "R3", "bus/strobe violations", viol - v0, 0);
    if (!wr) begin
      chk(!e_q, "R10", "read err", int'(e_q), 0);
      chk(r_q == exp_rd, "R10", "read data", int'(r_q), int'(exp_rd));
      chk(rd_idle - ri0 == 1 && wr_cnt == w0, "R10", "single read access", rd_idle - ri0, 1);
    end else if (exp_to) begin
      chk(e_q && !m_q, "R8", "timeout err/match", int'({e_q, m_q}), 2);
      if (!rdy_mode)
        chk(rd_busy - rb0 == MAX_POLLS && rd_idle == ri0, "R8", "poll count",
            rd_busy - rb0, MAX_POLLS);
      else
        chk(rd_busy == rb0 && rd_idle == ri0, "R9", "no reads on wait timeout",
            rd_busy - rb0 + rd_idle - ri0, 0);
      while (busy != 0) @(negedge clk);
    end else begin
      chk(wr_cnt - w0 == 1 && we_width == WE_CYC, "R2", "write pulse width",
          we_width, WE_CYC);
      chk(shadow[a[5:0]] == (d ^ {1'b0, msk}), "R2", "stored byte",
          int'(shadow[a[5:0]]), int'(d ^ {1'b0, msk}));
      chk(!e_q, "R7", "no error", int'(e_q), 0);
      chk(m_q == (msk == 0), "R7", "match flag", int'(m_q), int'(msk == 0));
      chk(r_q == (d ^ {1'b0, msk}), "R7", "confirm data", int'(r_q), int'(d ^ {1'b0, msk}));
      if (rdy_mode) begin
        chk(rd_busy == rb0, "R5", "no reads while busy", rd_busy - rb0, 0);
        chk(rd_idle - ri0 == 1, "R7", "one confirming read", rd_idle - ri0, 1);
      end else begin
        chk(rd_idle - ri0 == 2, "R4", "polls stop at first good read", rd_idle - ri0, 2);
        chk(blen < 8 || rd_busy - rb0 >= 1, "R4", "polled while busy", rd_busy - rb0, 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes idle in reset",
        int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    chk(!mem_dq_oe && !rsp_done && req_ready, "R1", "drive/done/ready in reset",
        int'({mem_dq_oe, rsp_done, req_ready}), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && req_ready, "R1", "idle after reset",
        int'({mem_ce_n, mem_oe_n, mem_we_n, req_ready}), 15);
    // directed corners
    run_txn(1'b0, 13'h0005, 8'h00, 1'b0, 0, 7'h00, 1'b0);
    run_txn(1'b1, 13'h0011, 8'hA5, 1'b0, 30, 7'h00, 1'b0);
    run_txn(1'b1, 13'h0012, 8'h3C, 1'b0, 25, 7'h00, 1'b0);
    run_txn(1'b1, 13'h0012, 8'h3D, 1'b0, 1, 7'h00, 1'b0);
    run_txn(1'b1, 13'h1FE3, 8'hC3, 1'b1, 40, 7'h00, 1'b0);
    run_txn(1'b1, 13'h0020, 8'h81, 1'b0, 20, 7'h14, 1'b0);
    run_txn(1'b1, 13'h0021, 8'h02, 1'b1, 20, 7'h40, 1'b0);
    run_txn(1'b1, 13'h0030, 8'hF0, 1'b0, 400, 7'h00, 1'b1);
    run_txn(1'b1, 13'h0031, 8'h0F, 1'b1, 400, 7'h00, 1'b1);
    run_txn(1'b0, 13'h0012, 8'h00, 1'b0, 0, 7'h00, 1'b0);
    // constrained random
    void'($urandom(32'h0C0FFEE1));
    for (int k = 0; k < 40; k++) begin
      bit wr = ($urandom % 10) < 6;
      logic [6:0] m = (($urandom % 5) == 0) ? 7'($urandom) : 7'h00;
      run_txn(wr, AW'($urandom), 8'($urandom), 1'($urandom), 2 + int'($urandom % 44),
              m, 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule